// File: doc/BRIEF.md
# Fuse Array Word-Read Pulse Sequencer

This block sits between a register bus and a one-time-programmable fuse macro. Software loads a start/end cycle pair for each of the five macro control pins. There is one set of pairs for read accesses and a second set for program accesses. Software then issues a word command that carries an address. A single cycle counter runs from zero. Every pin is driven while the count lies inside its window. On a read, the 32-bit word the macro presents is captured when the strobe pin falls. When the count reaches the largest programmed end value, the sequence stops and a sticky completion flag rises. Software clears the flag by writing a one to it.

A mode bit hands the pins to software instead. While manual mode is selected, the pins follow a manual control register, and word commands do not start the sequencer. Manual mode is the reset state, so the macro stays in standby until software enables the sequencer.

Top module: `fuse_autoread_seq`

## Requirements
- R1: After reset the mode register (offset 0x00, bit 0) reads 1, meaning manual. The completion flag, the captured word and every timing register read 0. The pins idle in standby: fz_sel_n=1, fz_pgm_n=1, fz_load=0, fz_strobe=0, fz_addr=0.
- R2: Timing registers hold the window start in bits [31:16] and the window end in bits [15:0], and read back as written. The program set for pins select, program-enable, load, address and strobe is at 0x28, 0x2C, 0x30, 0x34 and 0x38. The read set for the same pins in the same order is at 0x3C, 0x40, 0x44, 0x48 and 0x4C.
- R3: With the mode bit at 0, a command is a write to 0x24 with bit 0 set. The counter starts at 0 on the command edge. At the k-th rising edge after the command edge, each pin shows whether count k-1 lies in its window, with start <= count < end. fz_sel_n and fz_pgm_n are active-low; fz_load and fz_strobe are active-high. When the sequencer is idle, no pin is asserted.
- R4: If M is the largest end value of the selected set, the completion flag (0x18 bit 0) first reads 1 after the (M+1)-th rising edge after the command edge. Bit 0 of 0x24 reads 1 while the sequence runs and 0 once it has ended. An all-zero set ends after one cycle with no pin asserted.
- R5: On a read command (0x24 bit 1 = 1), the word on fz_rdata is captured at the edge where the strobe pin falls. It is readable at 0x20 and unchanged until a later capture.
- R6: The completion flag stays set until a write to 0x18 with bit 0 = 1. Writing 0 there leaves the flag set. If a clear and a completion fall on the same edge, the flag stays set.
- R7: A command written while a sequence runs is ignored. The running address, the captured word and the end timing are unchanged, and 0x24 bits [25:16] keep the first address.
- R8: With the mode bit at 1, the pins follow the manual register at 0x04: bit 0 gives fz_sel_n, bit 1 gives fz_pgm_n, bit 2 gives fz_load, bit 3 gives fz_strobe, and bits [25:16] give fz_addr. In this mode a command starts nothing and the completion flag stays 0.
- R9: A command with 0x24 bit 1 = 0 runs the program window set and captures no data.
- R10: The 10-bit address in 0x24 bits [25:16] appears on fz_addr only while the address window is active. Outside that window fz_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| fz_sel_n | output | 1 | Macro chip select, active low |
| fz_pgm_n | output | 1 | Macro program enable, active low |
| fz_load | output | 1 | Macro load control |
| fz_strobe | output | 1 | Macro strobe |
| fz_addr | output | 10 | Macro word address |
| fz_rdata | input | 32 | Word presented by the macro |

## Verification
The completion edge, which sets the sticky flag, can coincide with a software write that clears that flag. The bench provokes this by counting M cycles after the command edge and placing a write of 1 to 0x18 exactly on the completing edge. The flag must then still read 1, and a second clear must bring it to 0. A second collision, a new command landing on a running sequence, is judged through the captured word and the address read back from 0x24.

// File: rtl/fuse_seq_pkg.sv
// Package: shared constants and the timing-window type for the fuse
// word-read sequencer. Assumes a 32-bit register bus with byte offsets.
package fuse_seq_pkg;
    localparam int CNT_W   = 16;       // width of one window bound
    localparam int N_PIN   = 5;        // pins driven by a window
    localparam int BUS_AW  = 8;        // register offset width
    localparam int BUS_DW  = 32;       // register data width
    localparam int WORD_AW = 10;       // fuse word address width

    // pin order inside each window set (decoded by the register map)
    localparam int PIN_SEL  = 0;
    localparam int PIN_PGM  = 1;
    localparam int PIN_LOAD = 2;
    localparam int PIN_ADDR = 3;
    localparam int PIN_STB  = 4;

    // register offsets
    localparam int OFS_MODE     = 'h00;
    localparam int OFS_MANUAL   = 'h04;
    localparam int OFS_STATUS   = 'h18;
    localparam int OFS_WORD     = 'h20;
    localparam int OFS_CMD      = 'h24;
    localparam int OFS_WIN_BASE = 'h28;

    // command register fields
    localparam int CMD_GO       = 0;
    localparam int CMD_RD       = 1;
    localparam int CMD_ADDR_LSB = 16;

    // one window: start in the upper half, end in the lower half
    typedef struct packed {
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] last;
    } win_t;
endpackage

// File: rtl/fuse_win_decode.sv
// Window decoder: compares one count against a set of per-pin windows
// and reports the largest end value of the set.
// Assumes start <= count < end means "asserted"; an empty window never fires.
module fuse_win_decode
    import fuse_seq_pkg::*;
#(
    parameter int NP = N_PIN
) (
    input  logic [CNT_W-1:0]  cnt,
    input  win_t [NP-1:0]     wins,
    output logic [NP-1:0]     active,
    output logic [CNT_W-1:0]  last_max
);
    // one comparator pair per pin
    for (genvar g = 0; g < NP; g++) begin : g_pin
        assign active[g] = (cnt >= wins[g].first) && (cnt < wins[g].last);
    end

    // running maximum of the end values
    always_comb begin
        last_max = '0;
        for (int i = 0; i < NP; i++) begin
            if (wins[i].last > last_max) last_max = wins[i].last;
        end
    end
endmodule

// File: rtl/fuse_seq_core.sv
// Sequencer core: one counter that walks a selected window set, registered
// pin outputs, capture at the strobe falling edge, and a done pulse.
// Assumes windows stay unchanged while a sequence runs.
module fuse_seq_core
    import fuse_seq_pkg::*;
#(
    parameter int NP = N_PIN,
    parameter int AW = WORD_AW,
    parameter int DW = BUS_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic [AW-1:0]    start_addr,
    input  win_t [NP-1:0]    rd_wins,
    input  win_t [NP-1:0]    pg_wins,
    input  logic [DW-1:0]    fz_data,
    output logic             busy,
    output logic             ph_rd,
    output logic [AW-1:0]    addr_q,
    output logic [NP-1:0]    pins_q,
    output logic             done,
    output logic             cap_valid,
    output logic [DW-1:0]    cap_data
);
    logic [CNT_W-1:0] cnt_q, max_q, last_max;
    logic             busy_q, ph_q, sel_rd;
    logic [NP-1:0]    active;
    win_t [NP-1:0]    wins_sel;

    // running sequence uses its latched phase; idle looks at the new command
    assign sel_rd   = busy_q ? ph_q : start_rd;
    assign wins_sel = sel_rd ? rd_wins : pg_wins;

    fuse_win_decode #(.NP(NP)) u_dec (
        .cnt      (cnt_q),
        .wins     (wins_sel),
        .active   (active),
        .last_max (last_max)
    );

    assign done      = busy_q && (cnt_q == max_q);
    assign cap_valid = busy_q && ph_q && pins_q[PIN_STB] && !active[PIN_STB];
    assign cap_data  = fz_data;
    assign busy      = busy_q;
    assign ph_rd     = ph_q;

    // sequence control: start when idle, count, stop at the largest end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            cnt_q  <= '0;
            max_q  <= '0;
            addr_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                ph_q   <= start_rd;
                cnt_q  <= '0;
                max_q  <= last_max;
                addr_q <= start_addr;
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // registered pins so the macro sees glitch-free levels
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= busy_q ? active : '0;
    end

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> (pins_q == '0));
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> (addr_q == $past(addr_q) && ph_q == $past(ph_q)));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= max_q));
    p_stop_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == max_q) |=> !busy_q);
    p_no_cap_program_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ph_q) |-> !cap_valid);
endmodule

// File: rtl/fuse_regfile.sv
// Register file: mode, manual pin control, ten timing windows, sticky
// completion flag, captured word and the command register.
// Assumes single-cycle writes and a combinational read port.
module fuse_regfile
    import fuse_seq_pkg::*;
#(
    parameter int NP  = N_PIN,
    parameter int AW  = WORD_AW,
    parameter int DW  = BUS_DW,
    parameter int BAW = BUS_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [BAW-1:0]   bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             mode_q,
    output logic             man_sel_n,
    output logic             man_pgm_n,
    output logic             man_load,
    output logic             man_stb,
    output logic [AW-1:0]    man_addr,
    output win_t [NP-1:0]    rd_wins,
    output win_t [NP-1:0]    pg_wins,
    output logic             cmd_req,
    output logic             cmd_rd,
    output logic [AW-1:0]    cmd_addr,
    input  logic             seq_busy,
    input  logic             seq_rd,
    input  logic [AW-1:0]    seq_addr,
    input  logic             done,
    input  logic             cap_valid,
    input  logic [DW-1:0]    cap_data
);
    localparam int NWIN = 2 * NP;

    win_t [NWIN-1:0] win_q;
    logic            finish_q;
    logic [DW-1:0]   word_q;
    logic            clr_req;

    assign pg_wins  = win_q[NP-1:0];
    assign rd_wins  = win_q[NWIN-1:NP];
    assign cmd_req  = bus_wr && (bus_addr == BAW'(OFS_CMD)) && bus_wdata[CMD_GO];
    assign cmd_rd   = bus_wdata[CMD_RD];
    assign cmd_addr = bus_wdata[CMD_ADDR_LSB +: AW];
    assign clr_req  = bus_wr && (bus_addr == BAW'(OFS_STATUS)) && bus_wdata[0];

    // flag and captured word: completion wins over a same-edge clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            finish_q <= 1'b0;
            word_q   <= '0;
        end else begin
            if (done)         finish_q <= 1'b1;
            else if (clr_req) finish_q <= 1'b0;
            if (cap_valid)    word_q   <= cap_data;
        end
    end

    // software-written control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b1;
            man_sel_n <= 1'b1;
            man_pgm_n <= 1'b1;
            man_load  <= 1'b0;
            man_stb   <= 1'b0;
            man_addr  <= '0;
            win_q     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == BAW'(OFS_MODE)) mode_q <= bus_wdata[0];
            if (bus_addr == BAW'(OFS_MANUAL)) begin
                man_sel_n <= bus_wdata[0];
                man_pgm_n <= bus_wdata[1];
                man_load  <= bus_wdata[2];
                man_stb   <= bus_wdata[3];
                man_addr  <= bus_wdata[CMD_ADDR_LSB +: AW];
            end
            for (int k = 0; k < NWIN; k++) begin
                if (bus_addr == BAW'(OFS_WIN_BASE + 4 * k)) win_q[k] <= bus_wdata;
            end
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BAW'(OFS_MODE))   bus_rdata[0] = mode_q;
        if (bus_addr == BAW'(OFS_STATUS)) bus_rdata[0] = finish_q;
        if (bus_addr == BAW'(OFS_WORD))   bus_rdata    = word_q;
        if (bus_addr == BAW'(OFS_MANUAL)) begin
            bus_rdata[0] = man_sel_n;
            bus_rdata[1] = man_pgm_n;
            bus_rdata[2] = man_load;
            bus_rdata[3] = man_stb;
            bus_rdata[CMD_ADDR_LSB +: AW] = man_addr;
        end
        if (bus_addr == BAW'(OFS_CMD)) begin
            bus_rdata[CMD_GO] = seq_busy;
            bus_rdata[CMD_RD] = seq_rd;
            bus_rdata[CMD_ADDR_LSB +: AW] = seq_addr;
        end
        for (int k = 0; k < NWIN; k++) begin
            if (bus_addr == BAW'(OFS_WIN_BASE + 4 * k)) bus_rdata = win_q[k];
        end
    end

    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> finish_q);
    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !done) |=> !finish_q);
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_q && !clr_req) |=> finish_q);
endmodule

// File: rtl/fuse_autoread_seq.sv
// Top: fuse word-read sequencer. Connects the register file and the
// sequencer core and selects between manual and sequenced pin levels.
// Assumes the macro presents its word combinationally while strobed.
module fuse_autoread_seq
    import fuse_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    output logic                fz_sel_n,
    output logic                fz_pgm_n,
    output logic                fz_load,
    output logic                fz_strobe,
    output logic [WORD_AW-1:0]  fz_addr,
    input  logic [BUS_DW-1:0]   fz_rdata
);
    logic               mode_q, man_sel_n, man_pgm_n, man_load, man_stb;
    logic [WORD_AW-1:0] man_addr, cmd_addr, seq_addr;
    win_t [N_PIN-1:0]   rd_wins, pg_wins;
    logic               cmd_req, cmd_rd, seq_busy, seq_rd, done, cap_valid, go;
    logic [N_PIN-1:0]   pins_q;
    logic [BUS_DW-1:0]  cap_data;

    fuse_regfile u_regs (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .mode_q, .man_sel_n, .man_pgm_n, .man_load, .man_stb, .man_addr,
        .rd_wins, .pg_wins, .cmd_req, .cmd_rd, .cmd_addr,
        .seq_busy, .seq_rd, .seq_addr, .done, .cap_valid, .cap_data
    );

    // commands only start the sequencer in automatic mode
    assign go = cmd_req && !mode_q;

    fuse_seq_core u_core (
        .clk, .rst_n,
        .start      (go),
        .start_rd   (cmd_rd),
        .start_addr (cmd_addr),
        .rd_wins, .pg_wins,
        .fz_data    (fz_rdata),
        .busy       (seq_busy),
        .ph_rd      (seq_rd),
        .addr_q     (seq_addr),
        .pins_q, .done, .cap_valid, .cap_data
    );

    // pin source select: manual register or sequencer
    always_comb begin
        if (mode_q) begin
            fz_sel_n  = man_sel_n;
            fz_pgm_n  = man_pgm_n;
            fz_load   = man_load;
            fz_strobe = man_stb;
            fz_addr   = man_addr;
        end else begin
            fz_sel_n  = !pins_q[PIN_SEL];
            fz_pgm_n  = !pins_q[PIN_PGM];
            fz_load   = pins_q[PIN_LOAD];
            fz_strobe = pins_q[PIN_STB];
            fz_addr   = pins_q[PIN_ADDR] ? seq_addr : '0;
        end
    end

    p_manual_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && cmd_req && !seq_busy) |=> !seq_busy);
    p_addr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !seq_busy) |=> (fz_addr == '0 || mode_q));
endmodule

// File: tb/sim_fuse_autoread_seq.sv
// Directed bench for the fuse word-read sequencer with a behavioural macro.
module sim_fuse_autoread_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fz_sel_n, fz_pgm_n, fz_load, fz_strobe;
    logic [9:0]  fz_addr;
    logic [31:0] fz_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int ws [10];
    int we [10];

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] word_of(input logic [9:0] a);
        return {a[7:0] ^ 8'h5A, 6'b0, a, 8'hC3};
    endfunction

    // behavioural macro: word valid while selected, loaded and strobed
    assign fz_rdata = (!fz_sel_n && fz_load && fz_strobe) ? word_of(fz_addr) : 32'h0;

    fuse_autoread_seq u0 (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .fz_sel_n, .fz_pgm_n, .fz_load, .fz_strobe, .fz_addr, .fz_rdata
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_win(input int k, input int s, input int e);
        ws[k] = s; we[k] = e;
        bus_write(8'(8'h28 + 4 * k), {16'(s), 16'(e)});
    endtask

    function automatic logic [31:0] cmd_word(input logic [9:0] a, input bit rd);
        return {6'b0, a, 14'b0, rd, 1'b1};
    endfunction

    // issue a command and check every cycle of the pulse schedule
    task automatic run_seq(input logic [9:0] a, input bit rd);
        int base = rd ? 5 : 0;
        int m = 0;
        int perr = 0, aerr = 0, ferr = 0, eerr = 0;
        logic [31:0] v;
        for (int p = 0; p < 5; p++) if (we[base + p] > m) m = we[base + p];
        bus_write(8'h24, cmd_word(a, rd));
        for (int i = 0; i <= m; i++) begin
            bit act [5];
            @(posedge clk);
            #1;
            for (int p = 0; p < 5; p++) act[p] = (i >= ws[base + p]) && (i < we[base + p]);
            if (fz_sel_n !== !act[0] || fz_pgm_n !== !act[1] ||
                fz_load !== act[2] || fz_strobe !== act[4]) perr++;
            if (fz_addr !== (act[3] ? a : 10'h0)) aerr++;
            bus_read(8'h18, v);
            if (v[0] !== (i == m)) ferr++;
            bus_read(8'h24, v);
            if (v[0] !== (i < m)) eerr++;
        end
        chk(perr == 0, "R3", "pin window schedule mismatching cycles", perr, 0);
        chk(aerr == 0, "R10", "address gating mismatching cycles", aerr, 0);
        chk(ferr == 0, "R4", "completion flag timing mismatching cycles", ferr, 0);
        chk(eerr == 0, "R4", "enable bit readback mismatching cycles", eerr, 0);
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            bus_read(8'h18, v);
            if (v[0]) return;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h00, v); chk(v == 32'h1, "R1", "mode after reset", v, 1);
        bus_read(8'h18, v); chk(v == 32'h0, "R1", "flag after reset", v, 0);
        bus_read(8'h20, v); chk(v == 32'h0, "R1", "word after reset", v, 0);
        bus_read(8'h40, v); chk(v == 32'h0, "R1", "window after reset", v, 0);
        chk({fz_sel_n, fz_pgm_n, fz_load, fz_strobe} == 4'b1100 && fz_addr == 0,
            "R1", "standby pins", {fz_sel_n, fz_pgm_n, fz_load, fz_strobe}, 4'b1100);
    endtask

    task automatic t_windows();
        logic [31:0] v;
        for (int p = 0; p < 4; p++) set_win(p, 0, 1130);
        set_win(4, 110, 1110);
        for (int p = 5; p < 8; p++) set_win(p, 0, 11);
        set_win(8, 2, 10);
        set_win(9, 5, 8);
        bus_read(8'h38, v); chk(v == {16'd110, 16'd1110}, "R2", "program strobe window", v, {16'd110, 16'd1110});
        bus_read(8'h48, v); chk(v == {16'd2, 16'd10}, "R2", "read address window", v, {16'd2, 16'd10});
        bus_read(8'h4C, v); chk(v == {16'd5, 16'd8}, "R2", "read strobe window", v, {16'd5, 16'd8});
    endtask

    task automatic t_read();
        logic [31:0] v;
        bus_write(8'h00, 32'h0);
        run_seq(10'h155, 1'b1);
        bus_read(8'h20, v); chk(v == word_of(10'h155), "R5", "captured word", v, word_of(10'h155));
        repeat (5) @(posedge clk);
        bus_read(8'h20, v); chk(v == word_of(10'h155), "R5", "word held stable", v, word_of(10'h155));
        bus_write(8'h18, 32'h1);
        run_seq(10'h000, 1'b1);
        bus_read(8'h20, v); chk(v == word_of(10'h000), "R5", "second capture", v, word_of(10'h000));
    endtask

    task automatic t_flag();
        logic [31:0] v;
        bus_write(8'h18, 32'h0);
        bus_read(8'h18, v); chk(v[0] == 1'b1, "R6", "flag kept on zero write", v[0], 1);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, v); chk(v[0] == 1'b0, "R6", "flag cleared by one", v[0], 0);
        // clear landing on the completing edge
        bus_write(8'h24, cmd_word(10'h3FF, 1'b1));
        repeat (11) @(posedge clk);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, v); chk(v[0] == 1'b1, "R6", "completion beats clear", v[0], 1);
        bus_write(8'h18, 32'h1);
        bus_read(8'h18, v); chk(v[0] == 1'b0, "R6", "later clear works", v[0], 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        bus_write(8'h24, cmd_word(10'h0A5, 1'b1));
        bus_write(8'h24, cmd_word(10'h15A, 1'b1));
        bus_read(8'h24, v); chk(v[25:16] == 10'h0A5, "R7", "running address kept", v[25:16], 10'h0A5);
        wait_done();
        bus_read(8'h20, v); chk(v == word_of(10'h0A5), "R7", "word of first command", v, word_of(10'h0A5));
        repeat (4) @(posedge clk);
        bus_read(8'h24, v); chk(v[0] == 1'b0, "R7", "no second sequence", v[0], 0);
        bus_write(8'h18, 32'h1);
    endtask

    task automatic t_program();
        logic [31:0] v;
        run_seq(10'h044, 1'b0);
        bus_read(8'h20, v); chk(v == word_of(10'h0A5), "R9", "no capture in program run", v, word_of(10'h0A5));
        bus_write(8'h18, 32'h1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        for (int p = 5; p < 10; p++) set_win(p, 0, 0);
        run_seq(10'h011, 1'b1);
        bus_read(8'h20, v); chk(v == word_of(10'h0A5), "R4", "empty set captures nothing", v, word_of(10'h0A5));
        bus_write(8'h18, 32'h1);
    endtask

    task automatic t_manual();
        logic [31:0] v;
        bus_write(8'h00, 32'h1);
        bus_write(8'h04, {6'b0, 10'h2AB, 12'b0, 4'b1110});
        chk({fz_sel_n, fz_pgm_n, fz_load, fz_strobe} == 4'b0111 && fz_addr == 10'h2AB,
            "R8", "manual pins", {fz_sel_n, fz_pgm_n, fz_load, fz_strobe, 2'b0, fz_addr}, {4'b0111, 2'b0, 10'h2AB});
        set_win(9, 0, 3);
        bus_write(8'h24, cmd_word(10'h001, 1'b1));
        repeat (10) @(posedge clk);
        bus_read(8'h18, v); chk(v[0] == 1'b0, "R8", "manual command starts nothing", v[0], 0);
        chk({fz_sel_n, fz_pgm_n, fz_load, fz_strobe} == 4'b0111 && fz_addr == 10'h2AB,
            "R8", "manual pins unchanged", {fz_sel_n, fz_pgm_n, fz_load, fz_strobe}, 4'b0111);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_windows();
        t_read();
        t_flag();
        t_busy_ignore();
        t_program();
        t_zero();
        t_manual();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule